// File: doc/BRIEF.md
# Inter-core interrupt and mailbox command dispatcher

This block takes command writes from a core and turns each one into one or two register accesses on the register bank of a chosen target core. Three command kinds exist. An interrupt send sets a single bit in the target's interrupt set port. A mail send writes one of the target's mailbox words. A generic send writes an arbitrary 16-bit register address on the target. Mail and generic sends carry a four-bit byte-keep mask. When any keep bit is set, the block first reads the target word. It then writes back a merge in which kept bytes retain their old value and the other bytes come from the command's upper half.

Commands arrive on a valid/ready port together with a kind code and a flag that says whether the write was a full 64-bit access. The target side is a single request/acknowledge port. It carries the core number, a 16-bit address and 32-bit data. While a command is in flight the block reports busy and holds off new commands. A command that names a core outside the supported range, or that arrives in an unsupported form, is consumed and causes no target access.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset `busy` is 0, `tgt_req` is 0 and `cmd_ready` is 1.
- R2: The target core is `cmd_data[25:16]`. A command whose core number is at or above `NUM_CORES` is consumed with no target access, and every target access carries a core number below `NUM_CORES`.
- R3: Kind code 0 (interrupt send) issues one write and no read. The write goes to address 0x1008, and its data has only bit `cmd_data[4:0]` set.
- R4: Kind code 1 (mail send) targets address 0x1020 + (`cmd_data` AND 0x1C).
- R5: Kind code 2 (generic send) targets address `cmd_data[15:0]`.
- R6: For kind 1 or 2 with keep mask `cmd_data[30:27]` all zero, no read is issued and the written word equals `cmd_data[63:32]`.
- R7: For kind 1 or 2 with a nonzero keep mask, one read of the same core and address comes first. The following write carries, for each byte i (0 to 3), the read byte i when `cmd_data[27+i]` is 1, and otherwise `cmd_data[32+8i +: 8]`.
- R8: Kind 1 and kind 2 with `cmd_full64` = 0 are consumed with no target access, as is the reserved kind code 3. Kind 0 is accepted with either value of `cmd_full64`.
- R9: `busy` rises in the cycle after an accepted command that causes a target access. It stays high until the cycle after the final write is acknowledged. `cmd_ready` is low whenever `busy` is high.
- R10: While `tgt_req` is high and `tgt_ack` is low, `tgt_req`, `tgt_we`, `tgt_core`, `tgt_addr` and `tgt_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_kind | input | 2 | 0 interrupt, 1 mail, 2 generic, 3 reserved |
| cmd_full64 | input | 1 | Command was a full 64-bit write |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | Command in flight |
| tgt_req | output | 1 | Target access request |
| tgt_we | output | 1 | 1 write, 0 read |
| tgt_core | output | 10 | Target core number |
| tgt_addr | output | 16 | Target register address |
| tgt_wdata | output | 32 | Write data |
| tgt_ack | input | 1 | Access completed this cycle |
| tgt_rdata | input | 32 | Read data, valid with `tgt_ack` on reads |

## Verification
On every cycle the assertions check several properties. Target accesses never name an out-of-range core. Request fields stay frozen until acknowledged. An acknowledged read is followed directly by a write to the same address. A final write acknowledge clears busy, and busy only rises right after an accepted command. The bench scenarios are needed to show the values: the decoded address for each kind, the one-hot interrupt word, the byte merge against data returned by the target model, and the absence of any access for discarded commands.

// File: rtl/ipi_dispatch_pkg.sv
package ipi_dispatch_pkg;
  typedef enum logic [1:0] {
    KIND_IRQ  = 2'd0,
    KIND_MAIL = 2'd1,
    KIND_GEN  = 2'd2,
    KIND_RSVD = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } seq_state_e;

  localparam int unsigned CMD_W       = 64;
  localparam int unsigned CORE_LSB    = 16;
  localparam int unsigned KEEP_LSB    = 27;
  localparam int unsigned PAYLOAD_LSB = 32;
  localparam int unsigned VEC_W       = 5;
  localparam logic [15:0] IRQ_SET_ADDR = 16'h1008;
  localparam logic [15:0] MBOX_BASE    = 16'h1020;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_dispatch_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_W    = 10,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32
) (
  input  logic [1:0]          kind,
  input  logic                full64,
  input  logic [CMD_W-1:0]    cmd,
  output logic                go,
  output logic [CORE_W-1:0]   core,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W/8-1:0] keep,
  output logic [DATA_W-1:0]   payload
);
  localparam int unsigned NBYTES = DATA_W / 8;
  localparam logic [CORE_W:0] CORE_LIMIT = NUM_CORES[CORE_W:0];

  logic in_range;
  logic form_ok;

  assign core     = cmd[CORE_LSB +: CORE_W];
  assign in_range = ({1'b0, core} < CORE_LIMIT);

  always_comb begin
    form_ok = 1'b0;
    addr    = '0;
    keep    = '0;
    payload = '0;
    unique case (cmd_kind_e'(kind))
      KIND_IRQ: begin
        form_ok = 1'b1;
        addr    = ADDR_W'(IRQ_SET_ADDR);
        payload = DATA_W'(1) << cmd[VEC_W-1:0];
      end
      KIND_MAIL: begin
        form_ok = full64;
        addr    = ADDR_W'(MBOX_BASE) + ADDR_W'({cmd[4:2], 2'b00});
        keep    = cmd[KEEP_LSB +: NBYTES];
        payload = cmd[PAYLOAD_LSB +: DATA_W];
      end
      KIND_GEN: begin
        form_ok = full64;
        addr    = cmd[ADDR_W-1:0];
        keep    = cmd[KEEP_LSB +: NBYTES];
        payload = cmd[PAYLOAD_LSB +: DATA_W];
      end
      default: form_ok = 1'b0;
    endcase
  end

  assign go = form_ok & in_range;
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W/8-1:0] keep,
  input  logic [DATA_W-1:0]   old_word,
  input  logic [DATA_W-1:0]   new_word,
  output logic [DATA_W-1:0]   merged
);
  localparam int unsigned NBYTES = DATA_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = keep[b] ? old_word[b*8 +: 8] : new_word[b*8 +: 8];
  end
endmodule

// File: rtl/ipi_sequencer.sv
module ipi_sequencer
  import ipi_dispatch_pkg::*;
#(
  parameter int unsigned CORE_W = 10,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_fire,
  input  logic                dec_go,
  input  logic [CORE_W-1:0]   dec_core,
  input  logic [ADDR_W-1:0]   dec_addr,
  input  logic [DATA_W/8-1:0] dec_keep,
  input  logic [DATA_W-1:0]   dec_payload,
  input  logic [DATA_W-1:0]   merged,
  input  logic                tgt_ack,
  output logic [DATA_W/8-1:0] keep_q,
  output logic [DATA_W-1:0]   data_q,
  output logic                tgt_req,
  output logic                tgt_we,
  output logic [CORE_W-1:0]   tgt_core,
  output logic [ADDR_W-1:0]   tgt_addr,
  output logic                idle
);
  seq_state_e state_q, state_d;
  logic [CORE_W-1:0]   core_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                load_en;
  logic                data_en;
  logic [DATA_W-1:0]   data_d;

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    data_en = 1'b0;
    data_d  = data_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (cmd_fire && dec_go) begin
          load_en = 1'b1;
          data_en = 1'b1;
          data_d  = dec_payload;
          state_d = (|dec_keep) ? SQ_READ : SQ_WRITE;
        end
      end
      SQ_READ: begin
        if (tgt_ack) begin
          data_en = 1'b1;
          data_d  = merged;
          state_d = SQ_WRITE;
        end
      end
      SQ_WRITE: begin
        if (tgt_ack) state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      core_q  <= '0;
      addr_q  <= '0;
      keep_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_en) begin
        core_q <= dec_core;
        addr_q <= dec_addr;
        keep_q <= dec_keep;
      end
      if (data_en) data_q <= data_d;
    end
  end

  assign idle     = (state_q == SQ_IDLE);
  assign tgt_req  = (state_q != SQ_IDLE);
  assign tgt_we   = (state_q == SQ_WRITE);
  assign tgt_core = core_q;
  assign tgt_addr = addr_q;
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_dispatch_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_W    = 10,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_kind,
  input  logic              cmd_full64,
  input  logic [63:0]       cmd_data,
  output logic              busy,
  output logic              tgt_req,
  output logic              tgt_we,
  output logic [CORE_W-1:0] tgt_core,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic              tgt_ack,
  input  logic [DATA_W-1:0] tgt_rdata
);
  localparam int unsigned NBYTES = DATA_W / 8;

  logic                rst_meta_q, rst_sync_q;
  logic                dec_go;
  logic [CORE_W-1:0]   dec_core;
  logic [ADDR_W-1:0]   dec_addr;
  logic [NBYTES-1:0]   dec_keep;
  logic [DATA_W-1:0]   dec_payload;
  logic [NBYTES-1:0]   keep_q;
  logic [DATA_W-1:0]   data_q;
  logic [DATA_W-1:0]   merged;
  logic                idle;
  logic                cmd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ipi_cmd_decode #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_decode (
    .kind(cmd_kind), .full64(cmd_full64), .cmd(cmd_data),
    .go(dec_go), .core(dec_core), .addr(dec_addr),
    .keep(dec_keep), .payload(dec_payload)
  );

  ipi_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .keep(keep_q), .old_word(tgt_rdata), .new_word(data_q), .merged(merged)
  );

  ipi_sequencer #(
    .CORE_W(CORE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_q),
    .cmd_fire(cmd_fire), .dec_go(dec_go), .dec_core(dec_core),
    .dec_addr(dec_addr), .dec_keep(dec_keep), .dec_payload(dec_payload),
    .merged(merged), .tgt_ack(tgt_ack),
    .keep_q(keep_q), .data_q(data_q),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_core(tgt_core),
    .tgt_addr(tgt_addr), .idle(idle)
  );

  assign cmd_ready = idle & rst_sync_q;
  assign cmd_fire  = cmd_valid & cmd_ready;
  assign busy      = ~idle;
  assign tgt_wdata = data_q;
endmodule

// File: rtl/ipi_dispatch_checker.sv
module ipi_dispatch_checker #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_W    = 10,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              busy,
  input logic              tgt_req,
  input logic              tgt_we,
  input logic [CORE_W-1:0] tgt_core,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic [DATA_W-1:0] tgt_wdata,
  input logic              tgt_ack
);
  localparam logic [CORE_W:0] CORE_LIMIT = NUM_CORES[CORE_W:0];

  p_core_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> ({1'b0, tgt_core} < CORE_LIMIT));

  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_we) && $stable(tgt_core)
                               && $stable(tgt_addr) && $stable(tgt_wdata)));

  p_read_then_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_we && tgt_ack) |=> (tgt_req && tgt_we && $stable(tgt_addr)
                                         && $stable(tgt_core)));

  p_done_clears_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && tgt_we && tgt_ack) |=> !busy);

  p_busy_from_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_ready));

  p_ready_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tgt_req);
endmodule

bind ipi_dispatch ipi_dispatch_checker #(
  .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_core(tgt_core),
  .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack)
);

// File: tb/ipi_dispatch_test.sv
module ipi_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCORES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = 2'd0;
  logic        cmd_full64 = 1'b0;
  logic [63:0] cmd_data = '0;
  logic        busy, tgt_req, tgt_we;
  logic [9:0]  tgt_core;
  logic [15:0] tgt_addr;
  logic [31:0] tgt_wdata;
  logic        tgt_ack = 1'b0;
  logic [31:0] tgt_rdata = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int n_rd = 0, n_wr = 0;
  logic [9:0]  rd_core, wr_core;
  logic [15:0] rd_addr, wr_addr;
  logic [31:0] wr_data;
  int wait_cnt = 0;

  ipi_dispatch #(.NUM_CORES(NCORES)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_full64(cmd_full64), .cmd_data(cmd_data),
    .busy(busy), .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_core(tgt_core),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack),
    .tgt_rdata(tgt_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] bank_word(input logic [9:0] c, input logic [15:0] a);
    return {a, 6'd0, c} ^ 32'hA5C3_96E1;
  endfunction

  // Target register bank model: acknowledges after a random delay
  always @(negedge clk) begin
    if (!rst_n) begin
      tgt_ack = 1'b0;
      wait_cnt = 0;
    end else if (tgt_ack) begin
      tgt_ack = 1'b0;
    end else if (tgt_req) begin
      if (wait_cnt == 0) begin
        tgt_ack = 1'b1;
        if (tgt_we) begin
          n_wr++; wr_core = tgt_core; wr_addr = tgt_addr; wr_data = tgt_wdata;
        end else begin
          n_rd++; rd_core = tgt_core; rd_addr = tgt_addr;
          tgt_rdata = bank_word(tgt_core, tgt_addr);
        end
        wait_cnt = int'($urandom % 3);
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] kind, input logic full, input logic [63:0] d);
    int rd0, wr0, guard;
    bit go;
    logic [9:0]  core;
    logic [15:0] addr;
    logic [3:0]  keep;
    logic [31:0] nw, old, exp;
    core = d[25:16];
    go = (kind != 2'd3) && (kind == 2'd0 || full) && (core < NCORES);
    keep = (kind == 2'd0) ? 4'd0 : d[30:27];
    nw   = (kind == 2'd0) ? (32'd1 << d[4:0]) : d[63:32];
    addr = (kind == 2'd0) ? 16'h1008 :
           (kind == 2'd1) ? (16'h1020 + {11'd0, d[4:2], 2'b00}) : d[15:0];
    old = bank_word(core, addr);
    for (int b = 0; b < 4; b++) exp[b*8 +: 8] = keep[b] ? old[b*8 +: 8] : nw[b*8 +: 8];
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_full64 = full; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (go) begin
      chk(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
      chk(cmd_ready == 1'b0, "R9 ready low while busy", 64'(cmd_ready), 64'd0);
    end else begin
      chk(busy == 1'b0, "R2/R8 discarded stays idle", 64'(busy), 64'd0);
    end
    guard = 0;
    while (busy && guard < 50) begin @(negedge clk); guard++; end
    chk(!busy && cmd_ready, "R9 idle after completion", 64'(busy), 64'd0);
    if (!go) begin
      chk(n_wr == wr0 && n_rd == rd0, "R2/R8 no target access",
          64'(n_wr - wr0 + n_rd - rd0), 64'd0);
    end else begin
      chk(n_wr == wr0 + 1, "R3/R6/R7 one write", 64'(n_wr - wr0), 64'd1);
      chk(n_rd == rd0 + ((keep != 0) ? 1 : 0), "R6/R7 read count",
          64'(n_rd - rd0), 64'((keep != 0) ? 1 : 0));
      if (keep != 0)
        chk(rd_addr == addr && rd_core == core, "R7 read address",
            64'({rd_core, rd_addr}), 64'({core, addr}));
      chk(wr_core == core, "R2 write core", 64'(wr_core), 64'(core));
      chk(wr_addr == addr, (kind == 2'd0) ? "R3 address" :
                           (kind == 2'd1) ? "R4 address" : "R5 address",
          64'(wr_addr), 64'(addr));
      chk(wr_data == exp, (kind == 2'd0) ? "R3 data" :
                          (keep == 0) ? "R6 data" : "R7 merged data",
          64'(wr_data), 64'(exp));
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] hi, input logic [3:0] keep,
                                     input logic [9:0] core, input logic [15:0] lo);
    return {hi, 1'b0, keep, 1'b0, core, lo};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !tgt_req && cmd_ready, "R1 reset state",
        64'({busy, tgt_req, cmd_ready}), 64'b001);

    // directed corner cases
    send(2'd0, 1'b0, mk(32'h0, 4'h0, 10'd2, 16'h001F));   // R3 vector 31, 32-bit form
    send(2'd0, 1'b1, mk(32'hFFFF_FFFF, 4'hF, 10'd0, 16'h0000)); // R3 vector 0, keep ignored
    send(2'd1, 1'b1, mk(32'h1122_3344, 4'h0, 10'd1, 16'h001C)); // R4/R6 last mailbox
    send(2'd1, 1'b1, mk(32'hDEAD_BEEF, 4'h5, 10'd3, 16'h0008)); // R7 alternate bytes
    send(2'd2, 1'b1, mk(32'hCAFE_F00D, 4'hF, 10'd0, 16'hABCD)); // R7 all kept
    send(2'd2, 1'b1, mk(32'h0BAD_CAFE, 4'h0, 10'd3, 16'h1234)); // R5/R6
    send(2'd2, 1'b1, mk(32'h1, 4'h2, 10'd4, 16'h0040));         // R2 core = NUM_CORES
    send(2'd0, 1'b1, mk(32'h0, 4'h0, 10'h3FF, 16'h0003));       // R2 max core
    send(2'd1, 1'b0, mk(32'h5, 4'h1, 10'd1, 16'h0004));         // R8 mail not 64-bit
    send(2'd2, 1'b0, mk(32'h5, 4'h0, 10'd1, 16'h0004));         // R8 generic not 64-bit
    send(2'd3, 1'b1, mk(32'h5, 4'h0, 10'd1, 16'h0004));         // R8 reserved kind

    // constrained random
    for (int i = 0; i < 200; i++) begin
      logic [63:0] d;
      logic [1:0]  k;
      d = {$urandom, $urandom};
      d[25:16] = 10'($urandom % 6);
      k = 2'($urandom % 4);
      send(k, ($urandom % 8) != 0, d);
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule